// File: doc/BRIEF.md
# Two-Digit Serial Segment Display Driver

This block updates two common-anode seven-segment digits through a pair of 8-bit serial-in, parallel-out registers. Each register has its own output latch, and the two registers are chained: the serial output of the first register feeds the serial input of the second. A one-cycle `load` pulse captures two decimal digits. The block converts each digit to an active-low segment byte and sends the 16 bits out most significant bit first, using a data pin and a shift-clock pin. It then raises the latch pin once, so that both digits change at the same moment.

The latch pin is held low for the whole transfer. The shift clock runs at a fixed fraction of the system clock. The data pin only changes while the shift clock is low. The block also drives the registers' active-low clear pin and active-low output-enable pin, so the display stays dark until the first complete pair of digits has been latched. A load that arrives during a transfer is kept and sent after the current latch pulse.

Top module: `seg_chain_driver`

## Requirements
- R1: While `rst_n` is low, `mr_n` is low and `oe_n`, `latch_clk` and `shift_clk` are high, low and low respectively. `mr_n` goes high on the first clock after reset is released and then stays high.
- R2: `oe_n` stays high until the first rising edge of `latch_clk`, is low on the clock after that edge, and never returns high.
- R3: Each transfer gives exactly 16 rising edges of `shift_clk`, all while `latch_clk` is low. It ends with one rising edge of `latch_clk`, which happens while `shift_clk` is low.
- R4: Bits leave MSB first, and the byte for `digit_hi` is sent first. After the latch edge, the far register therefore holds the `digit_hi` pattern and the near register holds the `digit_lo` pattern.
- R5: Segment bytes are active low, with bit 0 = segment a through bit 6 = segment g and bit 7 = decimal point (always 1). The hex values for digits 0..9 are C0, F9, A4, B0, 99, 92, 82, F8, 80 and 90.
- R6: A digit value of 10..15 produces FF, which turns every segment of that digit off.
- R7: `ser_data` does not change while `shift_clk` is high. It is settled at least one system clock before each rising edge of `shift_clk`.
- R8: `shift_clk` is high for exactly `HALF_DIV` system clocks and low for `HALF_DIV` clocks between edges within a transfer, giving a period of 2*`HALF_DIV` clocks.
- R9: A `load` during a transfer is held. The most recent such request is sent after the current latch pulse, and no further transfer follows unless there is another `load`.
- R10: A `load` while idle drives `latch_clk` low on the next clock edge, which starts the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | One-cycle request to display the two digits |
| digit_hi | input | 4 | Digit for the far register (sent first) |
| digit_lo | input | 4 | Digit for the near register (sent last) |
| ser_data | output | 1 | Serial data to the first register |
| shift_clk | output | 1 | Shift clock to both registers |
| latch_clk | output | 1 | Storage-latch clock to both registers |
| mr_n | output | 1 | Active-low register clear |
| oe_n | output | 1 | Active-low register output enable |

## Verification
A wrong bit counter shows up as a latched pair that is shifted by whole bits: the digits appear on the wrong register or with rotated segments as soon as the first latch edge comes, and the number of shift-clock edges in that transfer differs from 16. A wrong phase counter changes the measured shift-clock period or high width, and this can be seen on the first edge of a transfer. A lost pending request or a misplaced transition out of the latch state shows as a missing or extra latch edge within one transfer time, or as the older digits being displayed.

// File: rtl/seg_chain_driver.sv
module seg_chain_driver #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [3:0] digit_hi,
  input  logic [3:0] digit_lo,
  output logic       ser_data,
  output logic       shift_clk,
  output logic       latch_clk,
  output logic       mr_n,
  output logic       oe_n
);
  localparam int PW = $clog2(2 * HALF_DIV) + 1;
  localparam logic [PW-1:0] PH_HI  = PW'(HALF_DIV - 1);
  localparam logic [PW-1:0] PH_END = PW'(2 * HALF_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LATCH} st_t;

  function automatic logic [7:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0: seg_of = 8'hC0;
      4'd1: seg_of = 8'hF9;
      4'd2: seg_of = 8'hA4;
      4'd3: seg_of = 8'hB0;
      4'd4: seg_of = 8'h99;
      4'd5: seg_of = 8'h92;
      4'd6: seg_of = 8'h82;
      4'd7: seg_of = 8'hF8;
      4'd8: seg_of = 8'h80;
      4'd9: seg_of = 8'h90;
      default: seg_of = 8'hFF;
    endcase
  endfunction

  st_t           state;
  logic [PW-1:0] ph;
  logic [3:0]    bitn;
  logic [15:0]   shreg;
  logic          sclk_q, latch_q, mr_q, oe_q;
  logic          pend;
  logic [3:0]    pend_hi, pend_lo;

  assign ser_data  = shreg[15];
  assign shift_clk = sclk_q;
  assign latch_clk = latch_q;
  assign mr_n      = mr_q;
  assign oe_n      = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ph      <= '0;
      bitn    <= '0;
      shreg   <= '0;
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      mr_q    <= 1'b0;
      oe_q    <= 1'b1;
      pend    <= 1'b0;
      pend_hi <= '0;
      pend_lo <= '0;
    end else begin
      mr_q <= 1'b1;
      if (load && state != S_IDLE) begin
        pend    <= 1'b1;
        pend_hi <= digit_hi;
        pend_lo <= digit_lo;
      end
      case (state)
        S_IDLE: begin
          if (load || pend) begin
            shreg   <= load ? {seg_of(digit_hi), seg_of(digit_lo)}
                            : {seg_of(pend_hi), seg_of(pend_lo)};
            pend    <= 1'b0;
            ph      <= '0;
            bitn    <= '0;
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
            state   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (ph == PH_END) begin
            ph     <= '0;
            sclk_q <= 1'b0;
            shreg  <= {shreg[14:0], 1'b0};
            if (bitn == 4'd15) state <= S_LATCH;
            else               bitn  <= bitn + 4'd1;
          end else begin
            ph <= ph + 1'b1;
            if (ph == PH_HI) sclk_q <= 1'b1;
          end
        end
        S_LATCH: begin
          if (ph == PH_HI) begin
            latch_q <= 1'b1;
            oe_q    <= 1'b0;
          end
          if (ph == PH_END) begin
            ph    <= '0;
            state <= S_IDLE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_chain_checker.sv
module seg_chain_checker #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ser_data,
  input logic shift_clk,
  input logic latch_clk,
  input logic mr_n,
  input logic oe_n
);
  localparam int CW = $clog2(HALF_DIV + 1) + 2;
  logic [CW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hcnt <= '0;
    else if (shift_clk) hcnt <= hcnt + 1'b1;
    else                hcnt <= '0;
  end

  assert_mr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mr_n |=> mr_n);
  assert_oe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_clk) |=> !oe_n);
  assert_oe_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !oe_n);
  assert_latch_low_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |-> !latch_clk);
  assert_latch_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_clk) |-> !shift_clk);
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |-> $stable(ser_data));
  assert_high_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_clk) |-> (hcnt == CW'(HALF_DIV)));
  assert_high_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= CW'(HALF_DIV));
endmodule

bind seg_chain_driver seg_chain_checker #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .shift_clk(shift_clk),
  .latch_clk(latch_clk), .mr_n(mr_n), .oe_n(oe_n)
);

// File: tb/seg_chain_driver_tb.sv
`timescale 1ns/1ps
module seg_chain_driver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [3:0] digit_hi = '0, digit_lo = '0;
  logic ser_data, shift_clk, latch_clk, mr_n, oe_n;

  int n_chk = 0, n_fail = 0;

  seg_chain_driver #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .digit_hi(digit_hi),
    .digit_lo(digit_lo), .ser_data(ser_data), .shift_clk(shift_clk),
    .latch_clk(latch_clk), .mr_n(mr_n), .oe_n(oe_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of two chained shift registers with output latches
  logic [7:0] r_near = '0, r_far = '0, q_near = '0, q_far = '0;
  int  rises = 0, rises_at_latch = 0, lat_rises = 0;
  time prev_rise = 0, per_min = 0, per_max = 0, last_data = 0, min_setup = 0;

  initial begin per_min = 1000000; min_setup = 1000000; end

  always @(ser_data) last_data = $time;

  always @(posedge shift_clk) begin
    r_far  <= {r_far[6:0], r_near[7]};
    r_near <= {r_near[6:0], ser_data};
    rises = rises + 1;
    if (prev_rise != 0) begin
      if ($time - prev_rise < per_min) per_min = $time - prev_rise;
      if ($time - prev_rise > per_max) per_max = $time - prev_rise;
    end
    prev_rise = $time;
    if ($time - last_data < min_setup) min_setup = $time - last_data;
  end

  always @(posedge latch_clk) begin
    q_near <= r_near;
    q_far  <= r_far;
    lat_rises = lat_rises + 1;
    rises_at_latch = rises;
  end

  always @(negedge latch_clk) begin
    rises = 0; prev_rise = 0; per_min = 1000000; per_max = 0; min_setup = 1000000;
  end

  function automatic logic [7:0] exp_seg(input int d);
    case (d)
      0: return 8'hC0; 1: return 8'hF9; 2: return 8'hA4; 3: return 8'hB0;
      4: return 8'h99; 5: return 8'h92; 6: return 8'h82; 7: return 8'hF8;
      8: return 8'h80; 9: return 8'h90;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_load(input int hi, input int lo);
    @(negedge clk);
    digit_hi = 4'(hi); digit_lo = 4'(lo); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_latch(input int target);
    int k = 0;
    while (lat_rises < target && k < 2000) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    check("R3", "latch edge count", lat_rises, target);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "mr_n in reset", mr_n, 0);
    check("R1", "oe_n in reset", oe_n, 1);
    check("R1", "latch in reset", latch_clk, 0);
    check("R1", "shift clk in reset", shift_clk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "mr_n after reset", mr_n, 1);
    check("R2", "oe_n before first latch", oe_n, 1);
  endtask

  task automatic t_update(input int hi, input int lo, input string req);
    int target = lat_rises + 1;
    pulse_load(hi, lo);
    wait_latch(target);
    check(req, "far register", q_far, exp_seg(hi));
    check(req, "near register", q_near, exp_seg(lo));
    check("R3", "shift edges per transfer", rises_at_latch, 16);
    check("R8", "min shift period", per_min, 2 * HALF * CLK_PERIOD);
    check("R8", "max shift period", per_max, 2 * HALF * CLK_PERIOD);
    check("R7", "data setup >= 1 clk", (min_setup >= CLK_PERIOD) ? 1 : 0, 1);
    check("R2", "oe_n after latch", oe_n, 0);
  endtask

  task automatic t_idle_start();
    int target = lat_rises + 1;
    repeat (5) @(negedge clk);
    check("R10", "latch high while idle", latch_clk, 1);
    @(negedge clk);
    digit_hi = 4'd8; digit_lo = 4'd0; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check("R10", "latch low one clk after load", latch_clk, 0);
    wait_latch(target);
    check("R10", "far register", q_far, exp_seg(8));
    check("R10", "near register", q_near, exp_seg(0));
  endtask

  task automatic t_pending();
    int t0 = lat_rises;
    pulse_load(1, 2);
    repeat (20) @(negedge clk);
    pulse_load(3, 4);
    repeat (5) @(negedge clk);
    pulse_load(5, 6);
    wait_latch(t0 + 1);
    check("R9", "first transfer far", q_far, exp_seg(1));
    check("R9", "first transfer near", q_near, exp_seg(2));
    wait_latch(t0 + 2);
    check("R9", "held transfer far", q_far, exp_seg(5));
    check("R9", "held transfer near", q_near, exp_seg(6));
    check("R3", "held transfer edges", rises_at_latch, 16);
    repeat (200) @(negedge clk);
    check("R9", "no extra transfer", lat_rises, t0 + 2);
  endtask

  initial begin
    t_reset();
    t_update(1, 2, "R4");
    t_update(3, 7, "R5");
    t_update(9, 4, "R5");
    t_update(5, 6, "R5");
    t_update(0, 8, "R4");
    t_update(10, 15, "R6");
    t_update(9, 12, "R6");
    t_idle_start();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule